// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a microcontroller external memory bus: an active-high address latch strobe and an active-low program-read strobe. It runs from the oscillator-rate clock and splits every machine cycle into twelve oscillator periods with a free-running phase counter. Both strobes are placed at fixed phases inside that cycle.

Three inputs shape each machine cycle:

- `ext_code` says that code is fetched from external program memory.
- `ale_off` turns off the free-running latch strobe.
- `xdata_req` is a one-period pulse that marks the next machine cycle as an external data access.

The block samples all three at the boundary between machine cycles. The settings then hold for the whole of the following cycle.

In an external data cycle the block drops one latch pulse and both program-read pulses. The latch pulse it keeps carries the data address.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While reset is low, `ale` is 0 and `psen_n` is 1. After reset is released, the first clock edge starts period 0 of a machine cycle. That first machine cycle runs with no external code, the latch strobe enabled and no data access, whatever the inputs are.
- R2: In a normal machine cycle (no data access, `ale_off`=0), `ale` is high in periods 0, 1, 6 and 7 and low in all other periods. This is two pulses per 12-period machine cycle, one every six oscillator periods.
- R3: A machine cycle is 12 periods long. `ext_code`, `ale_off` and the data-access request are sampled in period 11. A change to `ext_code` or `ale_off` that is undone before period 11 has no effect on the next cycle.
- R4: A one-cycle `xdata_req` pulse in any period 0..11 of a machine cycle, including period 11, makes the next machine cycle a data cycle. In a data cycle the latch pulse in periods 0-1 is suppressed and the pulse in periods 6-7 is kept.
- R5: When the cycle runs from external code with no data access, `psen_n` is low in periods 2-4 and 8-10 and high otherwise. This is two read pulses, each 3 periods wide, each starting right after a latch pulse ends.
- R6: In a data cycle `psen_n` stays high for the whole machine cycle, so both read pulses are skipped.
- R7: When the cycle does not run from external code, `psen_n` stays high for the whole machine cycle.
- R8: When `ale_off`=1, `ale` stays low in a non-data cycle. In a data cycle it is high only in periods 6-7.
- R9: `ale` high and `psen_n` low never occur in the same period. Every `ale` pulse lasts exactly 2 periods and every `psen_n` pulse lasts exactly 3 periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_code | input | 1 | Code is fetched from external program memory |
| xdata_req | input | 1 | One-period pulse: the next machine cycle is an external data access |
| ale_off | input | 1 | Disables the free-running latch strobe |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-read strobe, active low |

## Verification
The hardest situation to reach is a data request that arrives in the last period of a machine cycle. It must bypass the pending flag and still mark the next cycle. The stimulus table pulses the request either early in a cycle (period 3) or in its final period (period 10 on the drive side, which is captured at the boundary edge), so both paths are exercised. Other vectors combine a data cycle with the latch strobe disabled, which leaves a single kept latch pulse. Directed tests then change `ext_code` and undo the change before the cycle boundary. They also reset the block in the middle of a cycle while `ext_code` is held high, and check that the first cycle after reset ignores it.

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_code,
  input  logic xdata_req,
  input  logic ale_off,
  output logic ale,
  output logic psen_n
);

  localparam int CYC_LEN = 12;
  localparam int PH_W    = $clog2(CYC_LEN);
  localparam int HALF    = CYC_LEN / 2;
  localparam int ALE_W   = 2;
  localparam int RD_W    = 3;

  logic [PH_W-1:0] phase;
  logic ext_q, off_q, dcyc_q, pend_q;
  logic last, ale_early, ale_late, rd_slot, ale_nxt, rd_nxt;

  assign last      = (phase == PH_W'(CYC_LEN - 1));
  assign ale_early = (phase < PH_W'(ALE_W));
  assign ale_late  = (phase >= PH_W'(HALF)) && (phase < PH_W'(HALF + ALE_W));
  assign rd_slot   = ((phase >= PH_W'(ALE_W)) && (phase < PH_W'(ALE_W + RD_W))) ||
                     ((phase >= PH_W'(HALF + ALE_W)) && (phase < PH_W'(HALF + ALE_W + RD_W)));

  assign ale_nxt = (ale_early && !dcyc_q && !off_q) || (ale_late && (dcyc_q || !off_q));
  assign rd_nxt  = rd_slot && ext_q && !dcyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      ext_q  <= 1'b0;
      off_q  <= 1'b0;
      dcyc_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      phase <= last ? '0 : phase + 1'b1;
      if (last) begin
        ext_q  <= ext_code;
        off_q  <= ale_off;
        dcyc_q <= pend_q | xdata_req;
        pend_q <= 1'b0;
      end else if (xdata_req) begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale    <= 1'b0;
      psen_n <= 1'b1;
    end else begin
      ale    <= ale_nxt;
      psen_n <= !rd_nxt;
    end
  end

  // R3: phase counter stays inside one machine cycle
  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(CYC_LEN));

  // R9: strobes never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n));

  // R9: latch pulse is two periods wide
  a_r9_ale_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale ##1 !ale);

  // R9: read pulse is three periods wide
  a_r9_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

  // R6: no read strobe in a data cycle
  a_r6_data_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    dcyc_q |-> psen_n);

  // R7: no read strobe while running internal code
  a_r7_int_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_q |-> psen_n);

  // R8: disabled latch strobe stays low outside data cycles
  a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q && !dcyc_q) |-> !ale);

  // R4: a data cycle never starts with a latch pulse
  a_r4_drop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (dcyc_q && phase == PH_W'(1)) |-> !ale);

endmodule

// File: tb/xbus_strobe_gen_test.sv
module xbus_strobe_gen_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_code = 1'b0;
  logic xdata_req = 1'b0;
  logic ale_off = 1'b0;
  logic ale, psen_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xbus_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .ext_code(ext_code), .xdata_req(xdata_req),
    .ale_off(ale_off), .ale(ale), .psen_n(psen_n)
  );

  // {ext, off, dreq, late}: settings for the following machine cycle
  localparam int NVEC = 10;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b0000, 4'b1000, 4'b1010, 4'b1011, 4'b0010,
    4'b0100, 4'b0111, 4'b1100, 4'b1110, 4'b0000
  };

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // Checks the 12 periods of the current cycle (flags ce/co/cd) and drives the next one.
  task automatic run_cycle(input bit ne, input bit no, input bit nd, input bit nlate,
                           input bit drop, input bit ce, input bit co, input bit cd);
    for (int p = 0; p < 12; p++) begin
      logic exp_ale, exp_rd;
      exp_ale = ((p < 2) && !cd && !co) || ((p == 6 || p == 7) && (cd || !co));
      exp_rd  = ce && !cd && ((p >= 2 && p <= 4) || (p >= 8 && p <= 10));
      chk(ale, exp_ale, co ? "R8" : (cd ? "R4" : "R2"), $sformatf("ale period %0d", p));
      chk(psen_n, !exp_rd, cd ? "R6" : (!ce ? "R7" : "R5"), $sformatf("psen_n period %0d", p));
      chk(ale && !psen_n, 1'b0, "R9", "strobe overlap");
      if (p == 0) begin
        ext_code = ne;
        ale_off  = no;
      end
      if (drop && p == 5) ext_code = 1'b0;
      xdata_req = nd && (p == (nlate ? 10 : 3));
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ce, co, cd;
    ce = 0; co = 0; cd = 0;
    repeat (3) @(negedge clk);
    chk(ale, 1'b0, "R1", "ale in reset");
    chk(psen_n, 1'b1, "R1", "psen_n in reset");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_cycle(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0, ce, co, cd);
      ce = VEC[i][3];
      co = VEC[i][2];
      cd = VEC[i][1];
    end

    // R3: ext_code raised then dropped before period 11 leaves next cycle internal
    run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ce, co, cd);
    run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R1: reset mid-cycle with ext_code held high
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ale, 1'b0, "R1", "ale after mid-cycle reset");
    chk(psen_n, 1'b1, "R1", "psen_n after mid-cycle reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: first cycle after reset ignores ext_code, ALE at period 0
    run_cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule